// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block times the interval between chosen transitions of a fan tachometer signal. The incoming pulse train is brought into the clock domain by a two-stage synchronizer. A filter then requires a programmable number of consecutive matching samples before it accepts a new level. From the filtered level the block picks falling, rising or all transitions. It counts ticks of a prescaled clock (the system clock divided by a power of four) from one picked transition to the next.

Each completed interval is latched as the measured value. A one-cycle update strobe marks each new value, and a sticky flag shows that at least one full interval has been captured since measurement was enabled. Every captured value is compared with a threshold. The sense of the comparison is selectable: report slow fans (long periods) or fast fans (short periods). A match raises a sticky interrupt status when interrupts are enabled. The synchronized raw level and the filtered level are also brought out, so a stuck or noisy input can be observed.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset, `value` is 0 and `full_meas`, `value_upd` and `irq_sts` are all low.
- R2: `raw_level` shows `tach_in` after exactly two clock edges.
- R3: `deb_code` sets the filter length N as 3 - `deb_code` (0→3, 1→2, 2→1, 3→0). A synchronized pulse lasting N cycles or fewer never reaches `deb_level`. A level held for N+1 cycles does reach it.
- R4: `edge_sel` picks the transitions that bound an interval: 0 falling-to-falling, 1 rising-to-rising, 2 and 3 any transition to the next one.
- R5: The first picked transition after `enable` rises only starts timing. It produces no capture and no update strobe.
- R6: The captured value is floor(D / 4^n). D is the spacing of the picked transitions in clock cycles, and n is `div_exp`, clamped to 11.
- R7: When an interval holds more ticks than the value width can express, the captured value is the all-ones maximum.
- R8: `full_meas` rises with the first capture after enable and falls in the cycle after `enable` goes low.
- R9: `value_upd` is high for one cycle per capture, and `value` changes only in such cycles.
- R10: With `inv_limit` low, a capture strictly greater than `threshold` sets `irq_sts`. With `inv_limit` high, a capture strictly smaller than it sets `irq_sts`. A capture equal to `threshold` never sets it.
- R11: `irq_sts` can only be set while `irq_en` is high. It stays set until an `irq_clr` pulse clears it, and a capture in the same cycle as the clear takes precedence.
- R12: While `enable` is low, transitions produce no capture, and `value` keeps its last captured result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 1 | Raw tachometer signal, asynchronous |
| enable | input | 1 | Measurement enable |
| deb_code | input | 2 | Filter length code |
| edge_sel | input | 2 | Interval boundary selection |
| div_exp | input | 4 | Prescaler exponent, clock divided by 4^n |
| threshold | input | CNT_W (20) | Limit for the interrupt compare |
| inv_limit | input | 1 | 0: flag values above limit, 1: flag values below limit |
| irq_en | input | 1 | Allows interrupt status to set |
| irq_clr | input | 1 | Clear pulse for interrupt status |
| value | output | CNT_W (20) | Last captured interval in prescaled ticks |
| full_meas | output | 1 | A complete interval has been captured |
| value_upd | output | 1 | One-cycle strobe per capture |
| raw_level | output | 1 | Synchronized raw input level |
| deb_level | output | 1 | Filtered input level |
| irq_sts | output | 1 | Sticky threshold interrupt status |

## Verification
The assertions watch cycle-level rules on every cycle: the update strobe only appears with the full flag, the value moves only on a strobe, a disabled meter produces no strobe and no full flag, the filtered level only ever takes the synchronized level, and interrupt status only rises with interrupts enabled and drops on a clear. Other behaviours need whole stimulus sequences, so only the bench scenarios can show them. These are the exact tick counts under each prescaler setting, the choice of interval boundaries per edge mode, the rejection of short pulses for each filter length, saturation, and the direction of the threshold compare.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int DEB_W   = 2;
  localparam int MODE_W  = 2;
  localparam int EXP_W   = 4;

  typedef enum logic [MODE_W-1:0] {
    EDGE_FALL    = 2'd0,
    EDGE_RISE    = 2'd1,
    EDGE_ANY     = 2'd2,
    EDGE_ANY_ALT = 2'd3
  } edge_mode_e;

  // filter length: code 0 is the longest, code 3 disables filtering
  function automatic logic [DEB_W-1:0] filt_len(input logic [DEB_W-1:0] code);
    return {DEB_W{1'b1}} - code;
  endfunction
endpackage

// File: rtl/tach_input_cond.sv
module tach_input_cond
  import tach_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_in,
  input  logic [DEB_W-1:0] deb_code,
  output logic             raw_lvl,
  output logic             deb_lvl
);
  logic             sync1_q, sync2_q;
  logic             deb_q, deb_d;
  logic [DEB_W-1:0] run_q, run_d;
  logic [DEB_W-1:0] need;

  assign need = filt_len(deb_code);

  always_comb begin
    deb_d = deb_q;
    run_d = run_q;
    if (sync2_q == deb_q) begin
      run_d = '0;
    end else if (run_q >= need) begin
      deb_d = sync2_q;
      run_d = '0;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      deb_q   <= 1'b0;
      run_q   <= '0;
    end else begin
      sync1_q <= tach_in;
      sync2_q <= sync1_q;
      deb_q   <= deb_d;
      run_q   <= run_d;
    end
  end

  assign raw_lvl = sync2_q;
  assign deb_lvl = deb_q;
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler
  import tach_pkg::*;
#(
  parameter int MAX_EXP = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [EXP_W-1:0] exp_code,
  output logic             tick
);
  localparam int DIV_W = 2 * MAX_EXP;

  logic [EXP_W-1:0] exp_eff;
  logic [EXP_W:0]   shamt;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] pre_q, pre_d;

  always_comb begin
    exp_eff = (exp_code > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_code;
    shamt   = {exp_eff, 1'b0};
    // 4^n - 1; wraps to all ones when the shift equals the width
    lim     = (DIV_W'(1) << shamt) - 1'b1;
  end

  assign tick = run && (pre_q >= lim);

  always_comb begin
    if (!run || restart || tick) pre_d = '0;
    else                         pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/tach_interval.sv
module tach_interval
  import tach_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              deb_lvl,
  input  logic [MODE_W-1:0] edge_sel,
  input  logic              tick,
  output logic              sel_edge,
  output logic              cap_fire,
  output logic [CNT_W-1:0]  cap_val,
  output logic [CNT_W-1:0]  value,
  output logic              full,
  output logic              upd
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  edge_mode_e       mode;
  logic             prev_q;
  logic             rise, fall;
  logic             armed_q, armed_d;
  logic             full_q, full_d;
  logic             upd_q, upd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] val_q, val_d;

  assign mode = edge_mode_e'(edge_sel);
  assign rise = deb_lvl & ~prev_q;
  assign fall = ~deb_lvl & prev_q;

  always_comb begin
    unique case (mode)
      EDGE_FALL: sel_edge = fall;
      EDGE_RISE: sel_edge = rise;
      default:   sel_edge = rise | fall;
    endcase
  end

  // ticks counted so far plus the tick of this cycle, saturating
  assign cap_val  = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(tick);
  assign cap_fire = enable && sel_edge && armed_q;

  always_comb begin
    armed_d = armed_q;
    full_d  = full_q;
    cnt_d   = cnt_q;
    val_d   = val_q;
    upd_d   = 1'b0;
    if (!enable) begin
      armed_d = 1'b0;
      full_d  = 1'b0;
      cnt_d   = '0;
    end else if (sel_edge) begin
      armed_d = 1'b1;
      cnt_d   = '0;
      if (armed_q) begin
        val_d  = cap_val;
        full_d = 1'b1;
        upd_d  = 1'b1;
      end
    end else if (tick && cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      full_q  <= 1'b0;
      upd_q   <= 1'b0;
      cnt_q   <= '0;
      val_q   <= '0;
    end else begin
      prev_q  <= deb_lvl;
      armed_q <= armed_d;
      full_q  <= full_d;
      upd_q   <= upd_d;
      cnt_q   <= cnt_d;
      val_q   <= val_d;
    end
  end

  assign value = val_q;
  assign full  = full_q;
  assign upd   = upd_q;
endmodule

// File: rtl/tach_limit_irq.sv
module tach_limit_irq #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_fire,
  input  logic [CNT_W-1:0] cap_val,
  input  logic [CNT_W-1:0] threshold,
  input  logic             inv_limit,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             irq_sts
);
  logic hit;
  logic sts_q, sts_d;

  assign hit = inv_limit ? (cap_val < threshold) : (cap_val > threshold);

  always_comb begin
    sts_d = sts_q;
    if (irq_clr)                    sts_d = 1'b0;
    if (cap_fire && hit && irq_en)  sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= sts_d;
  end

  assign irq_sts = sts_q;
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import tach_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int MAX_EXP = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_in,
  input  logic             enable,
  input  logic [1:0]       deb_code,
  input  logic [1:0]       edge_sel,
  input  logic [3:0]       div_exp,
  input  logic [CNT_W-1:0] threshold,
  input  logic             inv_limit,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] value,
  output logic             full_meas,
  output logic             value_upd,
  output logic             raw_level,
  output logic             deb_level,
  output logic             irq_sts
);
  logic             deb_w;
  logic             tick_w;
  logic             edge_w;
  logic             fire_w;
  logic [CNT_W-1:0] cap_w;

  tach_input_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .tach_in  (tach_in),
    .deb_code (deb_code),
    .raw_lvl  (raw_level),
    .deb_lvl  (deb_w)
  );

  tach_prescaler #(.MAX_EXP(MAX_EXP)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (enable),
    .restart  (edge_w),
    .exp_code (div_exp),
    .tick     (tick_w)
  );

  tach_interval #(.CNT_W(CNT_W)) u_ivl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .deb_lvl  (deb_w),
    .edge_sel (edge_sel),
    .tick     (tick_w),
    .sel_edge (edge_w),
    .cap_fire (fire_w),
    .cap_val  (cap_w),
    .value    (value),
    .full     (full_meas),
    .upd      (value_upd)
  );

  tach_limit_irq #(.CNT_W(CNT_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_fire  (fire_w),
    .cap_val   (cap_w),
    .threshold (threshold),
    .inv_limit (inv_limit),
    .irq_en    (irq_en),
    .irq_clr   (irq_clr),
    .irq_sts   (irq_sts)
  );

  assign deb_level = deb_w;
endmodule

// File: rtl/tach_meter_chk.sv
module tach_meter_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             irq_en,
  input logic             irq_clr,
  input logic [CNT_W-1:0] value,
  input logic             full_meas,
  input logic             value_upd,
  input logic             raw_level,
  input logic             deb_level,
  input logic             irq_sts
);
  // R9
  upd_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    value_upd |-> full_meas);

  // R9
  value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !value_upd |-> $stable(value));

  // R12
  off_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !value_upd);

  // R8
  off_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !full_meas);

  // R3
  filt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(deb_level) |-> deb_level == $past(raw_level));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sts) |-> $past(irq_en));

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> (!irq_sts || value_upd));
endmodule

bind fan_tach_meter tach_meter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_fan_tach_meter.sv
module tb_fan_tach_meter;
  localparam int W = 10;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tach_in = 1'b0;
  logic         enable = 1'b0;
  logic [1:0]   deb_code = 2'd3;
  logic [1:0]   edge_sel = 2'd1;
  logic [3:0]   div_exp = 4'd0;
  logic [W-1:0] threshold = '0;
  logic         inv_limit = 1'b0;
  logic         irq_en = 1'b0;
  logic         irq_clr = 1'b0;
  logic [W-1:0] value;
  logic         full_meas, value_upd, raw_level, deb_level, irq_sts;

  int checks = 0;
  int errors = 0;
  int upd_total = 0;

  always #2 clk = ~clk;

  fan_tach_meter #(.CNT_W(W)) dut (.*);

  always @(negedge clk) if (value_upd) upd_total <= upd_total + 1;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int cyc);
    tach_in = lvl;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] mode, input logic [1:0] dc, input logic [3:0] ex);
    enable = 1'b0;
    tach_in = 1'b0;
    repeat (10) @(negedge clk);
    edge_sel = mode;
    deb_code = dc;
    div_exp = ex;
    enable = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wave(input int d, input int reps);
    for (int i = 0; i < reps; i++) begin
      drive(1'b1, d / 2);
      drive(1'b0, d - d / 2);
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 value", value, 0);
    check("R1 full", full_meas, 0);
    check("R1 upd", value_upd, 0);
    check("R1 irq", irq_sts, 0);
  endtask

  task automatic t_raw;
    tach_in = 1'b1;
    @(negedge clk);
    check("R2 after one edge", raw_level, 0);
    @(negedge clk);
    check("R2 after two edges", raw_level, 1);
    drive(1'b0, 10);
  endtask

  task automatic t_filter(input logic [1:0] dc);
    int n = 3 - dc;
    int seen;
    enable = 1'b0;
    deb_code = dc;
    drive(1'b0, 10);
    seen = 0;
    if (n > 0) begin
      tach_in = 1'b1;
      for (int i = 0; i < n; i++) begin @(negedge clk); if (deb_level) seen = 1; end
      tach_in = 1'b0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (deb_level) seen = 1; end
      check($sformatf("R3 short pulse code %0d", dc), seen, 0);
    end
    seen = 0;
    tach_in = 1'b1;
    for (int i = 0; i < n + 1; i++) begin @(negedge clk); if (deb_level) seen = 1; end
    tach_in = 1'b0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (deb_level) seen = 1; end
    check($sformatf("R3 long pulse code %0d", dc), seen, 1);
  endtask

  task automatic t_modes(input logic [1:0] mode, input int exp_v, input int exp_n);
    int u0;
    setup(mode, 2'd3, 4'd0);
    u0 = upd_total;
    drive(1'b1, 30);
    drive(1'b0, 50);
    drive(1'b1, 10);
    drive(1'b0, 20);
    repeat (10) @(negedge clk);
    check($sformatf("R4 value mode %0d", mode), value, exp_v);
    check($sformatf("R5 R9 strobes mode %0d", mode), upd_total - u0, exp_n);
  endtask

  task automatic t_first_edge;
    int u0;
    setup(2'd1, 2'd3, 4'd0);
    u0 = upd_total;
    drive(1'b1, 20);
    drive(1'b0, 20);
    check("R5 no capture on first edge", upd_total - u0, 0);
    check("R8 full low before capture", full_meas, 0);
    drive(1'b1, 20);
    drive(1'b0, 10);
    check("R8 full after capture", full_meas, 1);
    enable = 1'b0;
    @(negedge clk);
    check("R8 full cleared by disable", full_meas, 0);
  endtask

  task automatic t_div(input logic [3:0] ex, input int d);
    int f = 1;
    for (int i = 0; i < ex; i++) f = f * 4;
    setup(2'd1, 2'd3, ex);
    wave(d, 3);
    check($sformatf("R6 div exp %0d period %0d", ex, d), value, d / f);
  endtask

  task automatic t_sat;
    setup(2'd1, 2'd3, 4'd0);
    wave(1500, 2);
    check("R7 saturated value", value, MAXV);
  endtask

  task automatic t_irq(input int d, input logic inv, input logic en, input int exp_i);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    threshold = W'(40);
    inv_limit = inv;
    irq_en = en;
    setup(2'd1, 2'd3, 4'd0);
    wave(d, 2);
    check($sformatf("R10 R11 irq period %0d inv %0d en %0d", d, inv, en), irq_sts, exp_i);
  endtask

  task automatic t_clear;
    enable = 1'b0;
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R11 clear pulse", irq_sts, 0);
  endtask

  task automatic t_disable;
    int u0;
    logic [W-1:0] v0;
    setup(2'd1, 2'd3, 4'd0);
    wave(44, 2);
    v0 = value;
    check("R12 prior capture", v0, 44);
    enable = 1'b0;
    u0 = upd_total;
    wave(20, 4);
    check("R12 no strobe when off", upd_total - u0, 0);
    check("R12 value kept", value, v0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw();
    for (int c = 0; c < 4; c++) t_filter(2'(c));
    t_modes(2'd0, 60, 1);
    t_modes(2'd1, 80, 1);
    t_modes(2'd2, 10, 3);
    t_modes(2'd3, 10, 3);
    t_first_edge();
    t_div(4'd0, 37);
    t_div(4'd1, 50);
    t_div(4'd2, 100);
    t_sat();
    t_irq(50, 1'b0, 1'b1, 1);
    t_clear();
    t_irq(30, 1'b0, 1'b1, 0);
    t_irq(40, 1'b0, 1'b1, 0);
    t_irq(30, 1'b1, 1'b1, 1);
    t_irq(40, 1'b1, 1'b1, 0);
    t_irq(50, 1'b0, 1'b0, 0);
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule